// File: doc/BRIEF.md
# Adaptive Synchronizer Delay Tuner

This block is a digital controller for a code-controlled delay line placed in the data path ahead of a two-flop synchronizer. The synchronizer links two clock domains that derive from one common reference. With rationally related clocks, the data edge lands at only a few discrete phases within the sampling period. Those phases are spaced evenly, one step per distinct phase value. A sampling point that sits on one of those clusters fails far more often than a uniform-phase estimate predicts. The best offset puts the flop's critical phase about half a cluster spacing away from the clusters.

The tuner lives in the sampling clock domain. It watches the output of the first synchronizer flop and tries every delay code in turn, one measurement window per code. In each window it counts suspect cycles. A suspect cycle is one where the flop output seen at the rising edge disagrees with a second look half a cycle later, which shows late settling. After the last code, the tuner locks the quietest code and holds it. The delay line, the synchronizer flops and any analog detection lie outside this block.

A frequency-change request from the source domain crosses into the sampling domain through a toggle synchronizer. The request discards the lock and restarts the sweep.

The controller has four states:
- SETTLE: the newly applied code is given time to take effect.
- MEASURE: suspect cycles are counted over the window.
- COMPARE: the count is judged against the best so far, and the next code is chosen.
- LOCKED: the chosen code is held.

Its transitions are:
- SETTLE→MEASURE when the settle count expires.
- MEASURE→COMPARE when the window ends.
- COMPARE→SETTLE with the code incremented, when codes remain.
- COMPARE→LOCKED after the last code.
- Any state→SETTLE at code 0 on a restart.

Top module: `sync_delay_tuner`

## Requirements
- R1: An asynchronous active-low reset forces `dly_code` to 0 and `locked` to 0 at once. After release, the sweep begins at code 0 with no other stimulus.
- R2: Codes are visited in ascending order 0 to N_CODES-1. Each code is held for SETTLE_LEN + WIN_LEN + 1 sampling cycles. `dly_code` changes only on the edge that ends a COMPARE cycle, and never while a window is being counted.
- R3: A sampling cycle is suspect when `first_stage_q`, sampled at the rising edge that starts the cycle, differs from its value at the following falling edge. Suppose a code is applied at rising edge k. Its count is the number of suspect cycles among the WIN_LEN cycles that start at edges k+SETTLE_LEN through k+SETTLE_LEN+WIN_LEN-1. Suspect cycles outside those windows have no effect.
- R4: The selected code is the one with the smallest count. Among equal counts, the lowest code wins.
- R5: On the edge that ends the COMPARE cycle of code N_CODES-1, `dly_code` takes the selected code and `locked` rises to 1.
- R6: While locked, `dly_code` and `locked` stay constant whatever activity appears on `first_stage_q`.
- R7: Holding `freq_chg` high across exactly one rising edge of `clk_src` restarts the sweep. On the third rising edge of `clk_smp` after that source edge, `dly_code` becomes 0 and `locked` becomes 0. This works from the locked state and from mid-sweep.
- R8: `dly_code` never exceeds N_CODES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source-domain clock; samples `freq_chg` |
| clk_smp | input | 1 | Sampling-domain clock; runs the tuner |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| freq_chg | input | 1 | One source-cycle pulse signalling that a clock frequency was reprogrammed |
| first_stage_q | input | 1 | Output of the first synchronizer flop |
| dly_code | output | $clog2(N_CODES) | Delay-select code for the external delay line |
| locked | output | 1 | High once a code has been chosen and is being held |

## Verification
Per-code suspect rates are driven from a table keyed on the code the design presents. Some tables create ties, including an all-quiet table, so a design using a non-strict comparison would lock a higher code. Another table adds suspect cycles only during settle and compare cycles on an otherwise best code; a design that counted outside its window would move away from that code. Restarts are issued both while locked and mid-sweep, and the edge count is checked so that a missing or extra synchronizer stage shows up as a one-cycle shift. A reset arrives while locked, and a long quiet spell after lock would expose a design that keeps sweeping.

// File: rtl/sdt_pkg.sv
`timescale 1ns/100ps
package sdt_pkg;
    typedef enum logic [1:0] {
        TS_SETTLE  = 2'd0,
        TS_MEASURE = 2'd1,
        TS_COMPARE = 2'd2,
        TS_LOCKED  = 2'd3
    } tune_state_e;
endpackage

// File: rtl/sdt_chg_sync.sv
`timescale 1ns/100ps
// Carries a one-cycle frequency-change request from the source domain
// into the sampling domain as a toggle, then turns the toggle back into a pulse.
module sdt_chg_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic clk_smp,
    input  logic rst_n,
    input  logic chg_req,
    output logic restart_o
);
    logic                   req_tgl;
    logic [SYNC_STAGES:0]   sync_q;

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n)
            req_tgl <= 1'b0;
        else if (chg_req)
            req_tgl <= ~req_tgl;
    end

    always_ff @(posedge clk_smp or negedge rst_n) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-1:0], req_tgl};
    end

    assign restart_o = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sdt_suspect_det.sv
`timescale 1ns/100ps
// Flags a cycle whose rising-edge sample disagrees with the falling-edge look.
module sdt_suspect_det (
    input  logic clk_smp,
    input  logic rst_n,
    input  logic stage_in,
    output logic suspect_o
);
    logic rise_q;
    logic fall_q;

    always_ff @(posedge clk_smp or negedge rst_n) begin
        if (!rst_n)
            rise_q <= 1'b0;
        else
            rise_q <= stage_in;
    end

    always_ff @(negedge clk_smp or negedge rst_n) begin
        if (!rst_n)
            fall_q <= 1'b0;
        else
            fall_q <= stage_in;
    end

    assign suspect_o = rise_q ^ fall_q;
endmodule

// File: rtl/sdt_event_cnt.sv
`timescale 1ns/100ps
module sdt_event_cnt #(
    parameter int WIN_LEN = 16,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             suspect,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (clr)
            count_o <= '0;
        else if (en)
            count_o <= count_o + CNT_W'(suspect);
    end

    // R3: a window never holds more events than it has cycles
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(WIN_LEN));
endmodule

// File: rtl/sdt_sweep_fsm.sv
`timescale 1ns/100ps
module sdt_sweep_fsm
    import sdt_pkg::*;
#(
    parameter int N_CODES    = 6,
    parameter int CODE_W     = 3,
    parameter int WIN_LEN    = 16,
    parameter int SETTLE_LEN = 2,
    parameter int CNT_W      = 5,
    parameter int PH_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CNT_W-1:0]  ev_cnt,
    output logic              cnt_clr,
    output logic              cnt_en,
    output logic [CODE_W-1:0] dly_code,
    output logic              locked
);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(N_CODES - 1);
    localparam logic [PH_W-1:0]   SET_LAST  = PH_W'(SETTLE_LEN - 1);
    localparam logic [PH_W-1:0]   WIN_LAST  = PH_W'(WIN_LEN - 1);

    tune_state_e       st_q, st_nx;
    logic [PH_W-1:0]   ph_q;
    logic [CNT_W-1:0]  best_cnt_q;
    logic [CODE_W-1:0] best_code_q;
    logic              settle_done, win_done, take_new;
    logic [CODE_W-1:0] sel_code;

    assign settle_done = (st_q == TS_SETTLE)  && (ph_q == SET_LAST);
    assign win_done    = (st_q == TS_MEASURE) && (ph_q == WIN_LAST);
    // strict less-than keeps the lowest code on a tie
    assign take_new    = (dly_code == '0) || (ev_cnt < best_cnt_q);
    assign sel_code    = take_new ? dly_code : best_code_q;

    always_comb begin
        st_nx = st_q;
        if (restart) begin
            st_nx = TS_SETTLE;
        end else begin
            unique case (st_q)
                TS_SETTLE:  if (settle_done) st_nx = TS_MEASURE;
                TS_MEASURE: if (win_done)    st_nx = TS_COMPARE;
                TS_COMPARE: st_nx = (dly_code == LAST_CODE) ? TS_LOCKED : TS_SETTLE;
                TS_LOCKED:  st_nx = TS_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= TS_SETTLE;
        else
            st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q        <= '0;
            dly_code    <= '0;
            best_cnt_q  <= '0;
            best_code_q <= '0;
        end else if (restart) begin
            ph_q        <= '0;
            dly_code    <= '0;
            best_cnt_q  <= '0;
            best_code_q <= '0;
        end else begin
            unique case (st_q)
                TS_SETTLE: begin
                    ph_q <= settle_done ? '0 : ph_q + PH_W'(1);
                end
                TS_MEASURE: begin
                    if (!win_done)
                        ph_q <= ph_q + PH_W'(1);
                end
                TS_COMPARE: begin
                    ph_q        <= '0;
                    best_code_q <= sel_code;
                    if (take_new)
                        best_cnt_q <= ev_cnt;
                    if (dly_code == LAST_CODE)
                        dly_code <= sel_code;
                    else
                        dly_code <= dly_code + CODE_W'(1);
                end
                TS_LOCKED: begin
                    ph_q <= ph_q;
                end
            endcase
        end
    end

    assign locked  = (st_q == TS_LOCKED);
    assign cnt_clr = restart || settle_done;
    assign cnt_en  = (st_q == TS_MEASURE) && !restart;

    // R2: code frozen while a window is counted
    a_r2_code_stable_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_MEASURE && !restart) |=> $stable(dly_code));
    // R2: sweep steps up by one code
    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_COMPARE && dly_code != LAST_CODE && !restart)
        |=> (dly_code == CODE_W'($past(dly_code) + CODE_W'(1))));
    // R5: the last compare leads to lock
    a_r5_lock_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_COMPARE && dly_code == LAST_CODE && !restart) |=> locked);
    // R6: lock holds until a restart
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> (locked && $stable(dly_code)));
    // R7: restart drops lock and returns to code zero
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!locked && dly_code == '0));
    // R8: code stays in range
    a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        dly_code <= LAST_CODE);
endmodule

// File: rtl/sync_delay_tuner.sv
`timescale 1ns/100ps
module sync_delay_tuner #(
    parameter int N_CODES     = 6,
    parameter int WIN_LEN     = 16,
    parameter int SETTLE_LEN  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk_src,
    input  logic                       clk_smp,
    input  logic                       rst_n,
    input  logic                       freq_chg,
    input  logic                       first_stage_q,
    output logic [$clog2(N_CODES)-1:0] dly_code,
    output logic                       locked
);
    localparam int CODE_W = $clog2(N_CODES);
    localparam int CNT_W  = $clog2(WIN_LEN + 1);
    localparam int PH_MAX = (WIN_LEN > SETTLE_LEN) ? WIN_LEN : SETTLE_LEN;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    logic             restart;
    logic             suspect;
    logic             cnt_clr, cnt_en;
    logic [CNT_W-1:0] ev_cnt;

    sdt_chg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_chg (
        .clk_src   (clk_src),
        .clk_smp   (clk_smp),
        .rst_n     (rst_n),
        .chg_req   (freq_chg),
        .restart_o (restart)
    );

    sdt_suspect_det u_det (
        .clk_smp   (clk_smp),
        .rst_n     (rst_n),
        .stage_in  (first_stage_q),
        .suspect_o (suspect)
    );

    sdt_event_cnt #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk_smp),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .en      (cnt_en),
        .suspect (suspect),
        .count_o (ev_cnt)
    );

    sdt_sweep_fsm #(
        .N_CODES    (N_CODES),
        .CODE_W     (CODE_W),
        .WIN_LEN    (WIN_LEN),
        .SETTLE_LEN (SETTLE_LEN),
        .CNT_W      (CNT_W),
        .PH_W       (PH_W)
    ) u_fsm (
        .clk      (clk_smp),
        .rst_n    (rst_n),
        .restart  (restart),
        .ev_cnt   (ev_cnt),
        .cnt_clr  (cnt_clr),
        .cnt_en   (cnt_en),
        .dly_code (dly_code),
        .locked   (locked)
    );
endmodule

// File: tb/sync_delay_tuner_tb_top.sv
`timescale 1ns/100ps
module sync_delay_tuner_tb_top;
    localparam int N_CODES    = 6;
    localparam int WIN_LEN    = 16;
    localparam int SETTLE_LEN = 2;
    localparam int SYNC_ST    = 2;
    localparam int CODE_W     = $clog2(N_CODES);

    logic clk_src, clk_smp, rst_n, freq_chg, stage1;
    logic [CODE_W-1:0] dly_code;
    logic locked;

    sync_delay_tuner #(.N_CODES(N_CODES), .WIN_LEN(WIN_LEN),
                       .SETTLE_LEN(SETTLE_LEN), .SYNC_STAGES(SYNC_ST)) dut_i (
        .clk_src(clk_src), .clk_smp(clk_smp), .rst_n(rst_n), .freq_chg(freq_chg),
        .first_stage_q(stage1), .dly_code(dly_code), .locked(locked));

    int checks = 0, failures = 0;
    int rate [N_CODES];
    int noise_code = -1;
    bit susp_cur = 0, data_x = 0, s_now = 0;
    int cyc = 0, cidx = 0;
    // model: 0 settle, 1 measure, 2 compare, 3 locked
    int m_st = 0, m_ph = 0, m_code = 0, m_ev = 0, m_best = 0, m_bcode = 0, m_rcnt = 0;
    int hold_code = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code();
        int b = 0;
        for (int i = 1; i < N_CODES; i++)
            if (rate[i] < rate[b]) b = i;
        return b;
    endfunction

    task automatic set_rates(int a0, int a1, int a2, int a3, int a4, int a5);
        rate[0] = a0; rate[1] = a1; rate[2] = a2; rate[3] = a3; rate[4] = a4; rate[5] = a5;
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_code = 0; m_ev = 0; m_best = 0; m_bcode = 0; m_rcnt = 0;
            return;
        end
        if (m_rcnt > 0) begin
            m_rcnt--;
            if (m_rcnt == 0) begin
                m_st = 0; m_ph = 0; m_code = 0; m_ev = 0; m_best = 0; m_bcode = 0;
                return;
            end
        end
        case (m_st)
            0: if (m_ph == SETTLE_LEN - 1) begin m_st = 1; m_ph = 0; m_ev = 0; end
               else m_ph++;
            1: begin
                m_ev += int'(susp_cur);
                if (m_ph == WIN_LEN - 1) m_st = 2; else m_ph++;
            end
            2: begin
                if (m_code == 0 || m_ev < m_best) begin m_best = m_ev; m_bcode = m_code; end
                if (m_code == N_CODES - 1) begin m_st = 3; m_code = m_bcode; end
                else begin m_code++; m_st = 0; m_ph = 0; end
            end
            default: ;
        endcase
    endtask

    initial begin clk_smp = 0; forever #2.5 clk_smp = ~clk_smp; end
    initial begin
        clk_src = 0; #1;
        forever begin clk_src = 1; #5; clk_src = 0; #5; end
    end

    // reference model and per-cycle comparison (R2, R3, R5, R7, R8)
    always @(posedge clk_smp) begin
        #0.2 model_step();
        #1.8;
        chk(int'(dly_code) == m_code, "R2", "per-cycle delay code", int'(dly_code), m_code);
        chk(locked == (m_st == 3), "R5", "per-cycle locked flag", int'(locked), int'(m_st == 3));
        chk(int'(dly_code) < N_CODES, "R8", "code range", int'(dly_code), N_CODES - 1);
    end

    // stimulus: suspect pattern keyed on presented code (R3)
    initial begin
        stage1 = 0;
        forever begin
            @(posedge clk_smp);
            #1;
            cidx = int'(dly_code);
            s_now = 0;
            if (cidx < N_CODES) begin
                if ((cyc % 8) < rate[cidx]) s_now = 1;
                if (cidx == noise_code && m_st != 1) s_now = 1;
            end
            stage1 = data_x ^ s_now;
            susp_cur = s_now;
            cyc++;
            #2.5;
            data_x = cyc[1];
            stage1 = data_x;
        end
    end

    task automatic do_freq();
        @(posedge clk_src);
        #1 freq_chg = 1;
        @(posedge clk_src);
        m_rcnt = SYNC_ST + 1;
        #1 freq_chg = 0;
    endtask

    task automatic freq_and_check(bit was_locked);
        do_freq();
        @(posedge clk_smp); #1;
        @(posedge clk_smp); #1;
        if (was_locked)
            chk(locked == 1'b1, "R7", "lock kept before third edge", int'(locked), 1);
        @(posedge clk_smp); #1;
        chk(dly_code == '0, "R7", "code zero after restart", int'(dly_code), 0);
        chk(locked == 1'b0, "R7", "unlocked after restart", int'(locked), 0);
    endtask

    task automatic wait_lock(string req);
        int n = 0;
        while (m_st != 3 && n < 400) begin @(posedge clk_smp); n++; end
        @(negedge clk_smp);
        chk(locked == 1'b1, "R5", "lock reached", int'(locked), 1);
        chk(int'(dly_code) == exp_code(), req, "selected code", int'(dly_code), exp_code());
    endtask

    initial begin
        rst_n = 0; freq_chg = 0;
        set_rates(3, 5, 1, 4, 6, 2);
        repeat (3) @(posedge clk_smp);
        #1;
        chk(dly_code == '0, "R1", "code in reset", int'(dly_code), 0);
        chk(locked == 1'b0, "R1", "locked in reset", int'(locked), 0);
        rst_n = 1;
        @(posedge clk_smp); #1.5;
        chk(dly_code == '0 && !locked, "R1", "sweep starts at code 0", int'(dly_code), 0);

        wait_lock("R4");                       // unique minimum at code 2

        hold_code = int'(dly_code);
        set_rates(0, 0, 0, 0, 0, 0);
        repeat (150) @(posedge clk_smp);
        @(negedge clk_smp);
        chk(int'(dly_code) == hold_code, "R6", "code held while locked", int'(dly_code), hold_code);
        chk(locked == 1'b1, "R6", "lock held", int'(locked), 1);

        set_rates(4, 2, 7, 2, 2, 5);           // ties -> lowest code 1
        freq_and_check(1'b1);
        wait_lock("R4");

        set_rates(1, 1, 1, 1, 1, 1);
        freq_and_check(1'b1);
        repeat (40) @(posedge clk_smp);
        set_rates(0, 0, 0, 0, 0, 0);           // all tie -> code 0
        freq_and_check(1'b0);                  // R7 mid-sweep restart
        wait_lock("R4");

        set_rates(2, 2, 0, 1, 2, 2);           // R3: extra suspects only outside windows
        noise_code = 2;
        freq_and_check(1'b1);
        wait_lock("R3");
        noise_code = -1;

        set_rates(6, 6, 6, 6, 6, 1);           // best is last code
        @(negedge clk_smp);
        rst_n = 0;
        #0.5;
        chk(dly_code == '0, "R1", "async reset clears code", int'(dly_code), 0);
        chk(locked == 1'b0, "R1", "async reset clears lock", int'(locked), 0);
        repeat (2) @(posedge clk_smp);
        #1 rst_n = 1;
        wait_lock("R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_smp);
        checks++;
        failures++;
        $display("FAIL R5 watchdog expired act=%0d exp=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule